// File: doc/BRIEF.md
# Debug Mode State Controller

This block tracks the debug mode of a processor core. It holds one of three states: running with debug disabled, running with debug enabled, and halted. While halted the core runs no application code and only answers serial background commands. The block reads the reset cause flags and the level of the background pin when a reset event completes. It holds the debug-enable and clock-select bits. It watches the run-time halt sources and the resume command. From these it drives the core halt request, the illegal-instruction response, the debug clock selection and the keep-alive for clocks in stop mode.

Every event input is a single-cycle strobe sampled on the rising edge of `clk`. All outputs come from registers, so every output changes in the cycle after the strobe that causes it. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level, or a strobe.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_state` is 0 (run, debug off). `core_halt`, `ill_reset`, `ill_exc`, `wake_req`, `dbg_clk_div2` and `stop_clk_keep` are all 0.
- R2: In state 0, a `cfg_wr` with `cfg_dbg_en`=1 moves the block to state 1 (run, debug on) on the next edge. The same write loads `cfg_clk_div2` into the clock-select bit. A `cfg_wr` with `cfg_dbg_en`=1 in state 2 leaves the block in state 2.
- R3: A `cfg_wr` with `cfg_dbg_en`=0 moves the block to state 0 from any state. It wins over every halt source and over `go_cmd` in the same cycle.
- R4: In state 1, `halt_insn`, `bg_cmd` (with `lp_mode` low) or `bkpt_halt` moves the block to state 2 (halt), and `core_halt` rises. Several sources in one cycle give the same single transition. In state 0, `bg_cmd`, `bkpt_halt` and `trc_full` have no effect.
- R5: `trc_full` halts the block from state 1 only when `trc_mode` is 2'b01 or 2'b11. With 2'b00 or 2'b10 it has no effect.
- R6: A `bg_cmd` in state 1 while `lp_mode` is high raises `wake_req` on the next edge and leaves the state unchanged. `wake_req` stays high while `lp_mode` stays high. At the first edge where `lp_mode` is low, the block enters state 2 and `wake_req` falls.
- R7: `go_cmd` in state 2 returns the block to state 1. If a halt source is active in the same cycle, the block stays in state 2. `go_cmd` in state 1 has no effect.
- R8: `halt_insn` in state 0 leaves the state unchanged and pulses one response for exactly one cycle. The pulse is on `ill_reset` when `ird_sel`=0 and on `ill_exc` when `ird_sel`=1. In state 1, `halt_insn` gives no such pulse.
- R9: A `rst_evt` with `rc_por` or `rc_dbgfrc` set and `bgpin_lvl` low puts the block in state 2. It also sets both the debug-enable bit and the clock-select bit.
- R10: A `rst_evt` whose cause (`rc_iladdr`, `rc_ilop`, `rc_wdog`) has its matching halt flag (`hr_iladdr`, `hr_ilop`, `hr_wdog`) set puts the block in state 2 with both bits set. A cause without its flag leads to state 0.
- R11: A `rst_evt` with `rc_por` and `bgpin_lvl` high, or with any cause not listed in R9 or R10, leads to state 0. It also clears both bits.
- R12: `stop_clk_keep` equals the debug-enable bit, and it is 1 exactly when the state is not 0. `dbg_clk_div2` equals the clock-select bit.
- R13: `rst_evt` takes priority over every other input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| rst_evt | input | 1 | Strobe: a system reset has completed; causes are valid |
| rc_por | input | 1 | Cause: power-on reset |
| rc_dbgfrc | input | 1 | Cause: reset forced by the debugger |
| rc_iladdr | input | 1 | Cause: illegal address reset |
| rc_ilop | input | 1 | Cause: illegal opcode reset |
| rc_wdog | input | 1 | Cause: watchdog reset |
| hr_iladdr | input | 1 | Halt-on-reset flag for illegal address |
| hr_ilop | input | 1 | Halt-on-reset flag for illegal opcode |
| hr_wdog | input | 1 | Halt-on-reset flag for watchdog |
| bgpin_lvl | input | 1 | Background pin level sampled at reset |
| cfg_wr | input | 1 | Strobe: write the enable and clock-select bits |
| cfg_dbg_en | input | 1 | Debug-enable value to write |
| cfg_clk_div2 | input | 1 | Clock-select value to write |
| ird_sel | input | 1 | Illegal response select: 0 reset, 1 exception |
| lp_mode | input | 1 | Device is in a stop or wait low-power mode |
| halt_insn | input | 1 | Strobe: halt instruction executed |
| bg_cmd | input | 1 | Strobe: background command received |
| bkpt_halt | input | 1 | Strobe: breakpoint trigger set to halt |
| trc_full | input | 1 | Strobe: trace buffer full |
| trc_mode | input | TRC_W | Trace recording mode |
| go_cmd | input | 1 | Strobe: resume command |
| mode_state | output | 2 | 0 run/debug off, 1 run/debug on, 2 halt |
| core_halt | output | 1 | Core halt request |
| ill_reset | output | 1 | One-cycle illegal-instruction reset request |
| ill_exc | output | 1 | One-cycle illegal-instruction exception request |
| wake_req | output | 1 | Request to leave low-power mode before halting |
| dbg_clk_div2 | output | 1 | 1: debug clock is CPU clock / 2; 0: alternate clock |
| stop_clk_keep | output | 1 | Keep CPU and debug clocks running in stop mode |

## Verification
The bench targets these corner cases:

- **Priority in one cycle.** It sends a resume together with a breakpoint in halt, and a disable write together with a halt source or a resume. A design with the wrong order would wrongly resume or would halt while disabled.
- **Passive trace modes.** It runs both passive trace modes. A design that decodes only one mode bit would halt in one of them.
- **Wake from low power.** It sends a background command during low power. A design that halts at once would enter halt without raising the wake request.
- **Reset causes.** It sends each reset cause with and without its halt flag and with both pin levels. A design that mixes up the pairs, or does not set both bits on a halt boot, would show the wrong state or clock select.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    DM_OFF  = 2'd0,
    DM_RUN  = 2'd1,
    DM_HALT = 2'd2
  } dm_state_e;

  typedef struct packed {
    logic por;
    logic dbgfrc;
    logic iladdr;
    logic ilop;
    logic wdog;
  } rst_cause_t;

  typedef struct packed {
    logic iladdr;
    logic ilop;
    logic wdog;
  } halt_on_t;

endpackage

// File: rtl/dbgm_boot_eval.sv
module dbgm_boot_eval
  import dbgm_pkg::*;
(
  input  rst_cause_t cause,
  input  halt_on_t   hon,
  input  logic       pin_lvl,
  output logic       boot_halt
);

  localparam int NPAIR = 3;

  logic [NPAIR-1:0] cause_v;
  logic [NPAIR-1:0] flag_v;
  logic [NPAIR-1:0] hit_v;

  assign cause_v = {cause.iladdr, cause.ilop, cause.wdog};
  assign flag_v  = {hon.iladdr, hon.ilop, hon.wdog};

  // each reset cause halts only when paired with its own flag
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign hit_v[i] = cause_v[i] & flag_v[i];
  end

  // power-on or forced reset with the pin held low boots into halt
  assign boot_halt = ((cause.por | cause.dbgfrc) & ~pin_lvl) | (|hit_v);

endmodule

// File: rtl/dbgm_halt_merge.sv
module dbgm_halt_merge #(
  parameter int                     TRC_W     = 2,
  parameter logic [(1<<TRC_W)-1:0]  OBTR_MASK = 'b1010
) (
  input  logic             halt_insn,
  input  logic             bg_live,
  input  logic             wake_done,
  input  logic             bkpt_halt,
  input  logic             trc_full,
  input  logic [TRC_W-1:0] trc_mode,
  output logic             halt_src
);

  localparam int NMODES = 1 << TRC_W;

  logic [NMODES-1:0] mode_hot;
  logic              trc_halt;

  // one decode slot per recording mode; only obtrusive modes may halt
  for (genvar i = 0; i < NMODES; i++) begin : g_mode
    assign mode_hot[i] = (trc_mode == TRC_W'(i)) & OBTR_MASK[i];
  end

  assign trc_halt = trc_full & (|mode_hot);
  assign halt_src = halt_insn | bg_live | wake_done | bkpt_halt | trc_halt;

endmodule

// File: rtl/dbgm_cfg_regs.sv
module dbgm_cfg_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_load,
  input  logic boot_halt,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_clk,
  output logic en_q,
  output logic clk_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      clk_q <= 1'b0;
    end else if (boot_load) begin
      en_q  <= boot_halt;
      clk_q <= boot_halt;
    end else if (cfg_wr) begin
      en_q  <= cfg_en;
      clk_q <= cfg_clk;
    end
  end

  assert_boot_sets_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_load && boot_halt) |=> (en_q && clk_q));

  assert_plain_boot_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_load && !boot_halt) |=> (!en_q && !clk_q));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbgm_pkg::*;
#(
  parameter int                    TRC_W     = 2,
  parameter logic [(1<<TRC_W)-1:0] OBTR_MASK = 'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_evt,
  input  logic             rc_por,
  input  logic             rc_dbgfrc,
  input  logic             rc_iladdr,
  input  logic             rc_ilop,
  input  logic             rc_wdog,
  input  logic             hr_iladdr,
  input  logic             hr_ilop,
  input  logic             hr_wdog,
  input  logic             bgpin_lvl,
  input  logic             cfg_wr,
  input  logic             cfg_dbg_en,
  input  logic             cfg_clk_div2,
  input  logic             ird_sel,
  input  logic             lp_mode,
  input  logic             halt_insn,
  input  logic             bg_cmd,
  input  logic             bkpt_halt,
  input  logic             trc_full,
  input  logic [TRC_W-1:0] trc_mode,
  input  logic             go_cmd,
  output logic [1:0]       mode_state,
  output logic             core_halt,
  output logic             ill_reset,
  output logic             ill_exc,
  output logic             wake_req,
  output logic             dbg_clk_div2,
  output logic             stop_clk_keep
);

  dm_state_e  state_q, state_d;
  rst_cause_t cause;
  halt_on_t   hon;
  logic       boot_halt;
  logic       halt_src;
  logic       bg_live, wake_done;
  logic       wake_q, wake_d;
  logic       clr_en;
  logic       ill_hit;
  logic       ill_rst_q, ill_exc_q;
  logic       en_q, clk_q;

  assign cause = '{por: rc_por, dbgfrc: rc_dbgfrc, iladdr: rc_iladdr,
                   ilop: rc_ilop, wdog: rc_wdog};
  assign hon   = '{iladdr: hr_iladdr, ilop: hr_ilop, wdog: hr_wdog};

  dbgm_boot_eval u_boot (
    .cause     (cause),
    .hon       (hon),
    .pin_lvl   (bgpin_lvl),
    .boot_halt (boot_halt)
  );

  // background command halts directly only when awake
  assign bg_live   = bg_cmd & ~lp_mode;
  assign wake_done = wake_q & ~lp_mode;

  dbgm_halt_merge #(.TRC_W(TRC_W), .OBTR_MASK(OBTR_MASK)) u_merge (
    .halt_insn (halt_insn),
    .bg_live   (bg_live),
    .wake_done (wake_done),
    .bkpt_halt (bkpt_halt),
    .trc_full  (trc_full),
    .trc_mode  (trc_mode),
    .halt_src  (halt_src)
  );

  dbgm_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_load (rst_evt),
    .boot_halt (boot_halt),
    .cfg_wr    (cfg_wr),
    .cfg_en    (cfg_dbg_en),
    .cfg_clk   (cfg_clk_div2),
    .en_q      (en_q),
    .clk_q     (clk_q)
  );

  assign clr_en = cfg_wr & ~cfg_dbg_en;

  // priority: reset event, then disable write, then per-state events
  always_comb begin
    state_d = state_q;
    if (rst_evt) begin
      state_d = boot_halt ? DM_HALT : DM_OFF;
    end else if (clr_en) begin
      state_d = DM_OFF;
    end else begin
      unique case (state_q)
        DM_OFF:  if (cfg_wr && cfg_dbg_en) state_d = DM_RUN;
        DM_RUN:  if (halt_src)             state_d = DM_HALT;
        DM_HALT: if (go_cmd && !halt_src)  state_d = DM_RUN;
        default: state_d = DM_OFF;
      endcase
    end
  end

  // pending wake lives only while the block stays in run with debug on
  assign wake_d = (state_d == DM_RUN) &
                  ((wake_q & lp_mode) |
                   ((state_q == DM_RUN) & bg_cmd & lp_mode));

  assign ill_hit = (state_q == DM_OFF) & halt_insn & ~rst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= DM_OFF;
      wake_q    <= 1'b0;
      ill_rst_q <= 1'b0;
      ill_exc_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wake_q    <= wake_d;
      ill_rst_q <= ill_hit & ~ird_sel;
      ill_exc_q <= ill_hit & ird_sel;
    end
  end

  assign mode_state    = state_q;
  assign core_halt     = (state_q == DM_HALT);
  assign ill_reset     = ill_rst_q;
  assign ill_exc       = ill_exc_q;
  assign wake_req      = wake_q;
  assign dbg_clk_div2  = clk_q;
  assign stop_clk_keep = en_q;

  assert_enable_matches_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != DM_OFF) == en_q));

  assert_go_resumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DM_HALT && go_cmd && !halt_insn && !bg_cmd && !bkpt_halt &&
     !trc_full && !rst_evt && !cfg_wr) |=> (state_q == DM_RUN));

  assert_illegal_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ill_rst_q, ill_exc_q}));

  assert_illegal_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DM_OFF && halt_insn && !rst_evt) |=> (ill_rst_q || ill_exc_q));

  assert_passive_trace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DM_RUN && trc_full && trc_mode == TRC_W'(0) && !halt_insn &&
     !bg_cmd && !bkpt_halt && !wake_q && !rst_evt && !cfg_wr) |=> (state_q == DM_RUN));

  assert_wake_only_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state_q == DM_RUN));

  assert_disable_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_dbg_en && !rst_evt) |=> (state_q == DM_OFF));

  assert_run_halt_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DM_RUN && bkpt_halt && !rst_evt && !cfg_wr) |=> core_halt);

endmodule

// File: tb/sim_dbg_mode_ctrl.sv
module sim_dbg_mode_ctrl;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_evt = 0, rc_por = 0, rc_dbgfrc = 0, rc_iladdr = 0, rc_ilop = 0, rc_wdog = 0;
  logic hr_iladdr = 0, hr_ilop = 0, hr_wdog = 0, bgpin_lvl = 1;
  logic cfg_wr = 0, cfg_dbg_en = 0, cfg_clk_div2 = 0, ird_sel = 0, lp_mode = 0;
  logic halt_insn = 0, bg_cmd = 0, bkpt_halt = 0, trc_full = 0, go_cmd = 0;
  logic [1:0] trc_mode = 2'd0;
  logic [1:0] mode_state;
  logic core_halt, ill_reset, ill_exc, wake_req, dbg_clk_div2, stop_clk_keep;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .rc_por(rc_por), .rc_dbgfrc(rc_dbgfrc),
    .rc_iladdr(rc_iladdr), .rc_ilop(rc_ilop), .rc_wdog(rc_wdog), .hr_iladdr(hr_iladdr),
    .hr_ilop(hr_ilop), .hr_wdog(hr_wdog), .bgpin_lvl(bgpin_lvl), .cfg_wr(cfg_wr),
    .cfg_dbg_en(cfg_dbg_en), .cfg_clk_div2(cfg_clk_div2), .ird_sel(ird_sel),
    .lp_mode(lp_mode), .halt_insn(halt_insn), .bg_cmd(bg_cmd), .bkpt_halt(bkpt_halt),
    .trc_full(trc_full), .trc_mode(trc_mode), .go_cmd(go_cmd), .mode_state(mode_state),
    .core_halt(core_halt), .ill_reset(ill_reset), .ill_exc(ill_exc), .wake_req(wake_req),
    .dbg_clk_div2(dbg_clk_div2), .stop_clk_keep(stop_clk_keep)
  );

  // vector: req[16:13] st0[12:11] hi bg bp tf tm[6:5] go cw ce exp[1:0]
  localparam int NV = 17;
  localparam logic [16:0] VT [NV] = '{
    {4'd4,  2'd1, 1'b1,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0,1'b0, 2'd2}, // R4 halt insn
    {4'd4,  2'd1, 1'b0,1'b1,1'b0,1'b0, 2'd0, 1'b0,1'b0,1'b0, 2'd2}, // R4 bg cmd
    {4'd4,  2'd1, 1'b0,1'b0,1'b1,1'b0, 2'd0, 1'b0,1'b0,1'b0, 2'd2}, // R4 breakpoint
    {4'd4,  2'd1, 1'b1,1'b1,1'b1,1'b0, 2'd0, 1'b0,1'b0,1'b0, 2'd2}, // R4 all at once
    {4'd4,  2'd0, 1'b0,1'b1,1'b0,1'b0, 2'd0, 1'b0,1'b0,1'b0, 2'd0}, // R4 bg ignored off
    {4'd4,  2'd0, 1'b0,1'b0,1'b1,1'b1, 2'd1, 1'b0,1'b0,1'b0, 2'd0}, // R4 bkpt/trc ignored off
    {4'd5,  2'd1, 1'b0,1'b0,1'b0,1'b1, 2'd1, 1'b0,1'b0,1'b0, 2'd2}, // R5 mode 01
    {4'd5,  2'd1, 1'b0,1'b0,1'b0,1'b1, 2'd3, 1'b0,1'b0,1'b0, 2'd2}, // R5 mode 11
    {4'd5,  2'd1, 1'b0,1'b0,1'b0,1'b1, 2'd0, 1'b0,1'b0,1'b0, 2'd1}, // R5 mode 00
    {4'd5,  2'd1, 1'b0,1'b0,1'b0,1'b1, 2'd2, 1'b0,1'b0,1'b0, 2'd1}, // R5 mode 10
    {4'd7,  2'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0,1'b0, 2'd1}, // R7 go
    {4'd7,  2'd2, 1'b0,1'b0,1'b1,1'b0, 2'd0, 1'b1,1'b0,1'b0, 2'd2}, // R7 go + bkpt
    {4'd7,  2'd1, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0,1'b0, 2'd1}, // R7 go in run
    {4'd3,  2'd1, 1'b0,1'b0,1'b1,1'b0, 2'd0, 1'b0,1'b1,1'b0, 2'd0}, // R3 clear beats bkpt
    {4'd3,  2'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b1,1'b0, 2'd0}, // R3 clear beats go
    {4'd2,  2'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b1,1'b1, 2'd1}, // R2 enable
    {4'd2,  2'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b1,1'b1, 2'd2}  // R2 enable in halt
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go_to(input logic [1:0] s);
    rst_evt = 1; step(); rst_evt = 0;
    if (s != 2'd0) begin
      cfg_wr = 1; cfg_dbg_en = 1; step(); cfg_wr = 0; cfg_dbg_en = 0;
    end
    if (s == 2'd2) begin
      bkpt_halt = 1; step(); bkpt_halt = 0;
    end
  endtask

  task automatic boot(input logic por, frc, ia, io, wd, hia, hio, hwd, pin);
    rc_por = por; rc_dbgfrc = frc; rc_iladdr = ia; rc_ilop = io; rc_wdog = wd;
    hr_iladdr = hia; hr_ilop = hio; hr_wdog = hwd; bgpin_lvl = pin;
    rst_evt = 1; step(); rst_evt = 0;
    rc_por = 0; rc_dbgfrc = 0; rc_iladdr = 0; rc_ilop = 0; rc_wdog = 0;
    hr_iladdr = 0; hr_ilop = 0; hr_wdog = 0; bgpin_lvl = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "state", 32'(mode_state), 0);
    chk("R1", "outs", 32'({core_halt, ill_reset, ill_exc, wake_req, dbg_clk_div2, stop_clk_keep}), 0);
    rst_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      go_to(VT[i][12:11]);
      halt_insn = VT[i][10]; bg_cmd = VT[i][9]; bkpt_halt = VT[i][8]; trc_full = VT[i][7];
      trc_mode = VT[i][6:5]; go_cmd = VT[i][4]; cfg_wr = VT[i][3]; cfg_dbg_en = VT[i][2];
      step();
      halt_insn = 0; bg_cmd = 0; bkpt_halt = 0; trc_full = 0; trc_mode = 0;
      go_cmd = 0; cfg_wr = 0; cfg_dbg_en = 0;
      chk($sformatf("R%0d", VT[i][16:13]), $sformatf("vector %0d state", i),
          32'(mode_state), 32'(VT[i][1:0]));
      chk("R12", $sformatf("vector %0d keep", i), 32'(stop_clk_keep),
          32'(VT[i][1:0] != 2'd0));
    end

    // R8 illegal halt instruction
    go_to(2'd0);
    ird_sel = 0; halt_insn = 1; step(); halt_insn = 0;
    chk("R8", "ill_reset", 32'(ill_reset), 1);
    chk("R8", "ill_exc", 32'(ill_exc), 0);
    chk("R8", "state", 32'(mode_state), 0);
    step();
    chk("R8", "pulse width", 32'(ill_reset), 0);
    ird_sel = 1; halt_insn = 1; step(); halt_insn = 0;
    chk("R8", "ill_exc sel1", 32'({ill_reset, ill_exc}), 1);
    ird_sel = 0;
    go_to(2'd1);
    halt_insn = 1; step(); halt_insn = 0;
    chk("R8", "no pulse in run", 32'({ill_reset, ill_exc}), 0);

    // R6 wake from low power before halting
    go_to(2'd1);
    lp_mode = 1; bg_cmd = 1; step(); bg_cmd = 0;
    chk("R6", "wake raised", 32'(wake_req), 1);
    chk("R6", "still run", 32'(mode_state), 1);
    step();
    chk("R6", "wake held", 32'({wake_req, mode_state}), 32'({1'b1, 2'd1}));
    lp_mode = 0; step();
    chk("R6", "halt after wake", 32'(mode_state), 2);
    chk("R6", "wake dropped", 32'(wake_req), 0);

    // R2 R12 clock select
    go_to(2'd0);
    cfg_wr = 1; cfg_dbg_en = 1; cfg_clk_div2 = 0; step();
    chk("R12", "div2 zero", 32'({dbg_clk_div2, stop_clk_keep}), 32'(2'b01));
    cfg_clk_div2 = 1; step(); cfg_wr = 0; cfg_dbg_en = 0; cfg_clk_div2 = 0;
    chk("R2", "div2 loaded", 32'({dbg_clk_div2, mode_state}), 32'({1'b1, 2'd1}));

    // R9 boot into halt
    boot(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "por pin low", 32'({mode_state, dbg_clk_div2, stop_clk_keep}), 32'({2'd2, 2'b11}));
    boot(0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "forced pin low", 32'(mode_state), 2);
    // R11 plain boots
    boot(1, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R11", "por pin high", 32'({mode_state, dbg_clk_div2, stop_clk_keep}), 0);
    // R10 halt-on-reset pairs
    boot(0, 0, 1, 0, 0, 1, 0, 0, 1);
    chk("R10", "iladdr pair", 32'({mode_state, dbg_clk_div2}), 32'({2'd2, 1'b1}));
    boot(0, 0, 0, 1, 0, 0, 1, 0, 1);
    chk("R10", "ilop pair", 32'(mode_state), 2);
    boot(0, 0, 0, 0, 1, 0, 0, 1, 1);
    chk("R10", "wdog pair", 32'(mode_state), 2);
    boot(0, 0, 0, 0, 1, 1, 1, 0, 1);
    chk("R10", "wdog no flag", 32'({mode_state, stop_clk_keep}), 0);

    // R13 reset event beats other inputs
    go_to(2'd1);
    rst_evt = 1; bkpt_halt = 1; cfg_wr = 1; cfg_dbg_en = 1; step();
    rst_evt = 0; bkpt_halt = 0; cfg_wr = 0; cfg_dbg_en = 0;
    chk("R13", "reset wins", 32'({mode_state, stop_clk_keep}), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule